// File: doc/BRIEF.md
# Serial Register Access Port with Selectable Bit Order

This block is a slave-side serial control port that gives a host microcontroller read and write access to a bank of eight 8-bit control registers. The host drives an active-low select (`cs_n`), a serial clock (`sclk`) and a data line into the block (`sdi`). The block answers on a data line back to the host (`sdo`). All four serial signals are taken as synchronous to the system clock `clk`. The block finds the edges of `sclk` by comparing it with a registered copy. The host must hold each `sclk` level for at least two `clk` cycles.

Each access opens when `cs_n` falls. The first full byte is a command byte that carries a read/write flag and a register address. Every further full byte is a data byte for that one register, and this goes on until `cs_n` rises. A static input, `lsb_first`, picks the bit order on the wire. Either bit 0 of each byte travels first, or bit 7 does. Register values are kept in logical form, so a value written in one order reads back the same in the other. The whole bank is also driven out in parallel on `regs_o`, so that neighbouring logic can use the settings.

Top module: `serial_ctl_slave`

## Requirements
- R1: After reset, every register is 0x00 (so `regs_o` is all zero) and `sdo` is 0.
- R2: The first complete byte after `cs_n` falls is the command byte. Its logical bit 7 is the read flag (1 = read, 0 = write), bits 2:0 are the register address, and bits 6:3 are ignored.
- R3: `sdi` is sampled when a rising `sclk` edge is seen. When `lsb_first` = 0, bit 7 of each byte is sent first and bit 0 last, in both directions. `sdo` changes only in the `clk` cycle after a falling `sclk` edge, or when `cs_n` is high.
- R4: When `lsb_first` = 1, bit 0 of each byte is sent first and bit 7 last, in both directions.
- R5: In a write access, each complete data byte is stored into the addressed register at the rising `sclk` edge that samples its last bit. Further data bytes in the same access overwrite that same register, even when their value looks like a command.
- R6: In a read access, every data byte returns the current value of the addressed register on `sdo`, and the read leaves all registers unchanged.
- R7: `sdo` is 0 from the `clk` cycle after `cs_n` is seen high, for as long as `cs_n` stays high. It is also 0 throughout the command byte and throughout write accesses.
- R8: A byte cut short by `cs_n` rising is discarded. A partial data byte changes no register, and a partial command byte starts no access.
- R9: A new command byte is taken only after `cs_n` has gone high and then low again. `sclk` and `sdi` activity while `cs_n` is high has no effect.
- R10: `regs_o` carries register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsb_first | input | 1 | Bit order select: 1 = bit 0 first, 0 = bit 7 first; change only while `cs_n` is high |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| regs_o | output | 64 | Parallel copy of the register bank, register k on bits [8k+7:8k] |

## Verification
The bench goes after the places where byte framing can slip. It cuts a data byte short, cuts a command byte short, and sends a data byte that looks like a read command. A design that committed a partial byte would corrupt a register. One that re-framed the stream inside an access would treat the fake command as a fresh command and leave the register unwritten. The bench writes in one bit order and reads back in the other, which catches a design that stores wire order instead of logical value. It toggles `sclk` while `cs_n` is high and checks that `sdo` drops to 0 after select ends. This exposes a port that counts clocks while not selected, or one that leaves the last read bit driving the line.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Logical bit index carried by serial slot 'slot' of a byte of width 'w'.
  function automatic int unsigned order_index(input logic lsb, input int unsigned slot,
                                              input int unsigned w);
    return lsb ? slot : (w - 1 - slot);
  endfunction

endpackage

// File: rtl/sctl_edge.sv
module sctl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise_evt,
  output logic fall_evt,
  output logic start_evt
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign rise_evt  = sclk & ~sclk_q & ~cs_n;
  assign fall_evt  = ~sclk & sclk_q & ~cs_n;
  assign start_evt = ~cs_n & cs_q;
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int W = 8,
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rise_evt,
  input  logic             sdi,
  input  logic             lsb_first,
  output logic [W-1:0]     byte_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             byte_done
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(W - 1);

  logic [W-1:0]     sr;
  logic [W-1:0]     sr_nxt;
  logic [CNT_W-1:0] slot;

  always_comb begin
    if (lsb_first) sr_nxt = {sdi, sr[W-1:1]};
    else           sr_nxt = {sr[W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      slot <= '0;
    end else if (cs_n) begin
      sr   <= '0;
      slot <= '0;
    end else if (rise_evt) begin
      sr   <= sr_nxt;
      slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end
  end

  assign byte_o    = sr_nxt;
  assign slot_o    = slot;
  assign byte_done = rise_evt & (slot == LAST_SLOT);
endmodule

// File: rtl/sctl_seq.sv
module sctl_seq #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          byte_done,
  input  logic          rw_bit,
  input  logic [AW-1:0] addr_bits,
  output logic          in_cmd,
  output logic          rd_active,
  output logic [AW-1:0] addr_o,
  output logic          cmd_evt,
  output logic          wr_evt
);
  import sctl_pkg::*;

  phase_e        phase;
  logic          rd_q;
  logic [AW-1:0] addr_q;

  assign cmd_evt = byte_done & (phase == PH_CMD);
  assign wr_evt  = byte_done & (phase == PH_DATA) & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else if (cs_n) begin
      phase <= PH_CMD;
      rd_q  <= 1'b0;
    end else if (cmd_evt) begin
      phase  <= PH_DATA;
      rd_q   <= rw_bit;
      addr_q <= addr_bits;
    end
  end

  assign in_cmd    = (phase == PH_CMD);
  assign rd_active = (phase == PH_DATA) & rd_q;
  assign addr_o    = addr_q;
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank #(
  parameter int W  = 8,
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [N*W-1:0] regs_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  val <= '0;
      else if (wr_evt && wr_addr == AW'(g))        val <= wr_data;
    end
    assign regs_flat[g*W +: W] = val;
  end
endmodule

// File: rtl/sctl_txbit.sv
module sctl_txbit #(
  parameter int W  = 8,
  parameter int AW = 3,
  localparam int N = 1 << AW,
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fall_evt,
  input  logic             rd_active,
  input  logic             lsb_first,
  input  logic [CNT_W-1:0] slot,
  input  logic [AW-1:0]    addr,
  input  logic [N*W-1:0]   regs_flat,
  output logic             sdo
);
  import sctl_pkg::*;

  logic [W-1:0]     words [N];
  logic [CNT_W-1:0] bit_idx;
  logic             sdo_q;

  for (genvar g = 0; g < N; g++) begin : g_word
    assign words[g] = regs_flat[g*W +: W];
  end

  assign bit_idx = CNT_W'(order_index(lsb_first, 32'(slot), W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (cs_n)     sdo_q <= 1'b0;
    else if (fall_evt) sdo_q <= rd_active ? words[addr][bit_idx] : 1'b0;
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int NUM_REGS = 1 << ADDR_W,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lsb_first,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  // Named internal events, also watched by the bound checker.
  logic              rise_evt;
  logic              fall_evt;
  logic              start_evt;
  logic              byte_done;
  logic              cmd_evt;
  logic              wr_evt;
  logic              in_cmd;
  logic              rd_active;
  logic [DATA_W-1:0] rx_byte;
  logic [CNT_W-1:0]  slot;
  logic [ADDR_W-1:0] cur_addr;

  sctl_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .start_evt(start_evt)
  );

  sctl_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rise_evt (rise_evt),
    .sdi      (sdi),
    .lsb_first(lsb_first),
    .byte_o   (rx_byte),
    .slot_o   (slot),
    .byte_done(byte_done)
  );

  sctl_seq #(.AW(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .byte_done(byte_done),
    .rw_bit   (rx_byte[DATA_W-1]),
    .addr_bits(rx_byte[ADDR_W-1:0]),
    .in_cmd   (in_cmd),
    .rd_active(rd_active),
    .addr_o   (cur_addr),
    .cmd_evt  (cmd_evt),
    .wr_evt   (wr_evt)
  );

  sctl_regbank #(.W(DATA_W), .AW(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_evt   (wr_evt),
    .wr_addr  (cur_addr),
    .wr_data  (rx_byte),
    .regs_flat(regs_o)
  );

  sctl_txbit #(.W(DATA_W), .AW(ADDR_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .fall_evt (fall_evt),
    .rd_active(rd_active),
    .lsb_first(lsb_first),
    .slot     (slot),
    .addr     (cur_addr),
    .regs_flat(regs_o),
    .sdo      (sdo)
  );
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
  parameter int RW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdo,
  input logic [RW-1:0] regs_o,
  input logic          wr_evt,
  input logic          fall_evt,
  input logic          start_evt,
  input logic          in_cmd,
  input logic          rd_active
);
  a_r7_sdo_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (sdo == 1'b0));

  a_r7_sdo_low_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmd |-> (sdo == 1'b0));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(regs_o));

  a_r5_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(regs_o));

  a_r2_start_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> in_cmd);

  a_r6_read_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |=> $stable(regs_o));

  a_r3_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !cs_n) |=> $stable(sdo));
endmodule

bind serial_ctl_slave sctl_checker #(.RW(NUM_REGS*DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sdo      (sdo),
  .regs_o   (regs_o),
  .wr_evt   (wr_evt),
  .fall_evt (fall_evt),
  .start_evt(start_evt),
  .in_cmd   (in_cmd),
  .rd_active(rd_active)
);

// File: tb/serial_ctl_slave_test.sv
`timescale 1ns/1ps
module serial_ctl_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lsb_first = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [63:0] regs_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [7:0] mdl [8];
  int         pend_addr;
  logic [7:0] pend_val;

  always #2 clk = ~clk;

  serial_ctl_slave uut (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of the parallel bank against the model (R10, R5, R8, R9).
  always @(negedge clk) begin
    #1;
    if (mon_on && !done)
      for (int k = 0; k < 8; k++)
        chk(regs_o[8*k +: 8] == mdl[k], "R10 per-clock bank", regs_o[8*k +: 8], mdl[k]);
  end

  task automatic bit_xfer(input logic b, input bit commit, output logic seen);
    sdi = b;
    repeat (4) @(negedge clk);
    seen = sdo;
    sclk = 1'b1;
    @(negedge clk);
    if (commit) mdl[pend_addr] = pend_val;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int nbits, input bit commit_last,
                           output logic [7:0] got);
    logic s;
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsb_first ? i : 7 - i;
      bit_xfer(v[idx], commit_last && (i == 7), s);
      got[idx] = s;
    end
  endtask

  task automatic open_txn();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_txn();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R7 sdo low after select", sdo, 0);
  endtask

  task automatic do_write(input bit lsb, input int addr, input logic [3:0] junk,
                          input logic [7:0] vals [$]);
    logic [7:0] g;
    lsb_first = lsb;
    open_txn();
    send_byte({1'b0, junk, 3'(addr)}, 8, 0, g);
    chk(g == 8'h00, "R7 sdo low in command", g, 0);
    foreach (vals[j]) begin
      pend_addr = addr;
      pend_val  = vals[j];
      send_byte(vals[j], 8, 1, g);
      chk(g == 8'h00, "R7 sdo low in write", g, 0);
    end
    close_txn();
  endtask

  task automatic do_read(input bit lsb, input int addr, input logic [3:0] junk,
                         input int nbytes, input string req);
    logic [7:0] g;
    lsb_first = lsb;
    open_txn();
    send_byte({1'b1, junk, 3'(addr)}, 8, 0, g);
    chk(g == 8'h00, "R7 sdo low in command", g, 0);
    for (int j = 0; j < nbytes; j++) begin
      send_byte(8'h5A, 8, 0, g);
      chk(g == mdl[addr], req, g, mdl[addr]);
    end
    close_txn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(regs_o == 64'h0, "R1 bank reset", regs_o[31:0], 0);
    chk(sdo == 1'b0, "R1 sdo reset", sdo, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_on = 1;

    // R3: bit 7 first
    do_write(0, 3, 4'h0, '{8'hA5});
    do_read(0, 3, 4'h0, 1, "R3 read bit7-first");
    // R4: bit 0 first, cross-order readback
    do_write(1, 5, 4'h0, '{8'h3C});
    do_read(1, 5, 4'h0, 1, "R4 read bit0-first");
    do_read(0, 5, 4'h0, 1, "R4 cross-order read");
    do_write(1, 6, 4'h0, '{8'h81});
    do_read(0, 6, 4'h0, 1, "R4 asymmetric value");
    // R2: ignored bits 6:3 set
    do_write(0, 7, 4'hF, '{8'hC3});
    do_read(1, 7, 4'hA, 1, "R2 dont-care bits");
    // R5: stream of bytes, one that looks like a read command
    do_write(0, 1, 4'h0, '{8'h11, 8'h85, 8'h33});
    chk(regs_o[15:8] == 8'h33, "R5 last byte kept", regs_o[15:8], 8'h33);
    chk(regs_o[47:40] == 8'h3C, "R5 other reg untouched", regs_o[47:40], 8'h3C);
    // R6: multi-byte read
    do_read(1, 1, 4'h0, 3, "R6 repeated read");
    chk(regs_o[15:8] == 8'h33, "R6 read leaves reg", regs_o[15:8], 8'h33);

    // R8: partial data byte
    lsb_first = 0;
    pend_addr = 2;
    open_txn();
    send_byte(8'h02, 8, 0, g);
    pend_val = 8'h77;
    send_byte(8'h77, 8, 1, g);
    send_byte(8'hFF, 5, 0, g);
    close_txn();
    chk(regs_o[23:16] == 8'h77, "R8 partial data dropped", regs_o[23:16], 8'h77);
    // R8: partial command byte then a normal access
    open_txn();
    send_byte(8'h00, 4, 0, g);
    close_txn();
    do_read(0, 2, 4'h0, 1, "R8 after partial command");

    // R9: clock activity while deselected
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
      chk(sdo == 1'b0, "R9 sdo idle while deselected", sdo, 0);
    end
    do_read(1, 3, 4'h0, 1, "R9 framing after idle clocks");

    // R10: field positions of the parallel output
    for (int k = 0; k < 8; k++)
      chk(regs_o[8*k +: 8] == mdl[k], "R10 register slice", regs_o[8*k +: 8], mdl[k]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule